// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic and logic stage of a single-cycle processor datapath, together with the local decoder that drives it. The main control supplies a 2-bit instruction class. The instruction word supplies a 6-bit function field. A small decoder turns these two inputs into a 4-bit operation code. The ALU then applies that operation to two operands and returns a result, a zero flag and an overflow flag. The whole path is combinational, so all outputs settle in the same cycle as the inputs.

Memory-access instructions use the class "memory" to compute a base plus offset. Branch-on-equal uses the class "branch": it subtracts and tests the zero flag. Register-register instructions use the class "register", and in that class the function field picks the operation. In the 4-bit operation code, bit 3 means "subtract". This bit feeds the adder's invert-and-carry-in control directly, so the subtractor also serves the signed less-than compare.

Top module: `alu_core`

## Requirements
- R1: When `alu_op` is 2'b00, `alu_ctrl` is 4'b0110 and `result` is `opa + opb` modulo 2^WIDTH, whatever `funct` holds.
- R2: When `alu_op` is 2'b01, `alu_ctrl` is 4'b1110 and `result` is `opa - opb` modulo 2^WIDTH, whatever `funct` holds.
- R3: When `alu_op` is 2'b10, only `funct[3:0]` selects the code, and `funct[5:4]` has no effect. The mapping is: 0000 gives add (4'b0110), 0010 gives subtract (4'b1110), 0100 gives and (4'b0000), 0101 gives or (4'b0001), 0110 gives xor (4'b0010), 0111 gives nor (4'b0011), and 1010 gives set-less-than (4'b1111).
- R4: Codes 4'b0000, 4'b0001, 4'b0010 and 4'b0011 give the bitwise AND, OR, XOR and NOR of the operands.
- R5: Codes 4'b0110 and 4'b1110 give the sum and the difference of the operands, wrapped to WIDTH bits.
- R6: Code 4'b1111 gives 1 in bit 0 when `opa` is less than `opb` as two's-complement numbers, and 0 otherwise. All other result bits are 0.
- R7: `zero` is 1 exactly when every bit of `result` is 0. After a subtract, this means the operands are equal.
- R8: `overflow` is 1 only for add and subtract, and only when both effective operands have the same sign and the result has the other sign. It is 0 for every other code.
- R9: With `alu_op` 2'b11, or with a `funct[3:0]` value not listed in R3 under `alu_op` 2'b10, `alu_ctrl` is 4'b0100. In that case `result` is 0, `zero` is 1 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Instruction class from the main control |
| funct | input | 6 | Function field of the instruction |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| alu_ctrl | output | 4 | Decoded operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks assume that every input bit is known. Each check is gated on that condition, so an undriven operand or function field at start-up does not trigger a report. The stimulus always drives fully defined values. It walks every class and function-field combination with both don't-care function bits varied. It then sweeps every operand pair of a narrow instance for each legal operation, so that every carry, sign and wrap-around case occurs.

// File: rtl/alu_pkg.sv
// Shared definitions for the ALU and its decoder.
// Assumes: a 4-bit operation code whose bit 3 selects subtraction.
package alu_pkg;
    localparam int CODE_W      = 4;
    localparam int FUNCT_W     = 6;
    localparam int FUNCT_KEY_W = 4;

    typedef enum logic [CODE_W-1:0] {
        ALU_AND  = 4'b0000,
        ALU_OR   = 4'b0001,
        ALU_XOR  = 4'b0010,
        ALU_NOR  = 4'b0011,
        ALU_NONE = 4'b0100,
        ALU_ADD  = 4'b0110,
        ALU_SUB  = 4'b1110,
        ALU_SLT  = 4'b1111
    } alu_code_e;

    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_RSVD   = 2'b11
    } op_class_e;

    localparam logic [FUNCT_KEY_W-1:0] FK_ADD = 4'b0000;
    localparam logic [FUNCT_KEY_W-1:0] FK_SUB = 4'b0010;
    localparam logic [FUNCT_KEY_W-1:0] FK_AND = 4'b0100;
    localparam logic [FUNCT_KEY_W-1:0] FK_OR  = 4'b0101;
    localparam logic [FUNCT_KEY_W-1:0] FK_XOR = 4'b0110;
    localparam logic [FUNCT_KEY_W-1:0] FK_NOR = 4'b0111;
    localparam logic [FUNCT_KEY_W-1:0] FK_SLT = 4'b1010;
endpackage

// File: rtl/alu_ctrl_decode.sv
// Second-level operation decoder: instruction class plus function field
// gives the 4-bit ALU operation code.
// Assumes: only the low FUNCT_KEY_W function bits carry meaning.
module alu_ctrl_decode
    import alu_pkg::*;
(
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_code_e          code
);
    logic [FUNCT_KEY_W-1:0] key;
    logic                   inputs_known;

    assign key = funct[FUNCT_KEY_W-1:0];

    // Purpose: map the function key of a register-class instruction to an operation.
    function automatic alu_code_e reg_code(input logic [FUNCT_KEY_W-1:0] k);
        case (k)
            FK_ADD:  return ALU_ADD;
            FK_SUB:  return ALU_SUB;
            FK_AND:  return ALU_AND;
            FK_OR:   return ALU_OR;
            FK_XOR:  return ALU_XOR;
            FK_NOR:  return ALU_NOR;
            FK_SLT:  return ALU_SLT;
            default: return ALU_NONE;
        endcase
    endfunction

    // Purpose: choose the operation from the class, consulting funct only for register ops.
    always_comb begin
        case (op_class)
            CLS_MEM:    code = ALU_ADD;
            CLS_BRANCH: code = ALU_SUB;
            CLS_REG:    code = reg_code(key);
            default:    code = ALU_NONE;
        endcase
    end

    assign inputs_known = !$isunknown({op_class, funct});

    // Purpose: guard the class-level decode.
    always_comb begin
        if (inputs_known) begin
            p_mem_add_r1: assert (op_class != CLS_MEM || code == ALU_ADD)
                else $error("memory class did not decode to add");
            p_branch_sub_r2: assert (op_class != CLS_BRANCH || code == ALU_SUB)
                else $error("branch class did not decode to subtract");
            p_rsvd_none_r9: assert (op_class != CLS_RSVD || code == ALU_NONE)
                else $error("reserved class produced a defined code");
        end
    end
endmodule

// File: rtl/alu_logic_unit.sv
// Bitwise unit: AND, OR, XOR, NOR picked by a 2-bit selector.
// Assumes: the selector is the low two bits of a logic-group code.
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    // Purpose: apply the selected bitwise function.
    always_comb begin
        case (sel)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
// Adder/subtractor built from a ripple carry chain. Subtraction inverts b
// and injects a carry of one. Overflow is the carry into the sign bit XOR the carry out.
// Assumes: two's-complement operands.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    assign b_eff    = b ^ {WIDTH{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: one full-adder cell of the chain.
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    assign ovf = carry[WIDTH] ^ carry[MSB];

    // Purpose: overflow must agree with the operand/result sign rule.
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            p_ovf_sign_r8: assert (ovf == ((a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB])))
                else $error("carry-based overflow disagrees with sign rule");
        end
    end
endmodule

// File: rtl/alu_core.sv
// Top of the ALU stage: decoder, logic unit, shared adder and result select.
// Assumes: purely combinational use inside a single-cycle datapath.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]         alu_op,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   opa,
    input  logic [WIDTH-1:0]   opb,
    output logic [CODE_W-1:0]  alu_ctrl,
    output logic [WIDTH-1:0]   result,
    output logic               zero,
    output logic               overflow
);
    localparam int MSB = WIDTH - 1;

    alu_code_e        code;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] sum;
    logic             ovf_raw;
    logic             is_addsub;
    logic             less;

    alu_ctrl_decode u_decode (
        .op_class (alu_op),
        .funct    (funct),
        .code     (code)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a   (opa),
        .b   (opb),
        .sel (code[1:0]),
        .y   (logic_y)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a   (opa),
        .b   (opb),
        .sub (code[CODE_W-1]),
        .sum (sum),
        .ovf (ovf_raw)
    );

    assign alu_ctrl  = code;
    assign is_addsub = (code == ALU_ADD) || (code == ALU_SUB);
    assign less      = sum[MSB] ^ ovf_raw;

    // Purpose: route the selected unit's output to the result bus.
    always_comb begin
        case (code)
            ALU_AND, ALU_OR, ALU_XOR, ALU_NOR: result = logic_y;
            ALU_ADD, ALU_SUB:                  result = sum;
            ALU_SLT:                           result = {{(WIDTH-1){1'b0}}, less};
            default:                           result = '0;
        endcase
    end

    assign zero     = ~|result;
    assign overflow = ovf_raw & is_addsub;

    // Purpose: cross-check flags and special results against the operands.
    always_comb begin
        if (!$isunknown({alu_op, funct, opa, opb})) begin
            p_slt_bool_r6: assert (code != ALU_SLT || result[MSB:1] == '0)
                else $error("set-less-than result wider than one bit");
            p_slt_sign_r6: assert (code != ALU_SLT || result[0] == ($signed(opa) < $signed(opb)))
                else $error("set-less-than disagrees with signed compare");
            p_beq_equal_r7: assert (code != ALU_SUB || zero == (opa == opb))
                else $error("zero after subtract does not match equality");
            p_ovf_arith_r8: assert (!overflow || is_addsub)
                else $error("overflow raised outside add/subtract");
            p_undef_clear_r9: assert (code != ALU_NONE || (result == '0 && zero && !overflow))
                else $error("undefined code produced non-zero output");
        end
    end
endmodule

// File: tb/alu_core_bench.sv
// Bench: full decode sweep, then exhaustive operand sweep on a 5-bit instance.
module alu_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int SPAN       = 1 << W;
    localparam int HALF       = SPAN / 2;
    localparam int WDOG_LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   alu_op = '0;
    logic [5:0]   funct = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [3:0]   alu_ctrl;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.WIDTH(W)) u_alu_core (
        .alu_op   (alu_op),
        .funct    (funct),
        .opa      (opa),
        .opb      (opb),
        .alu_ctrl (alu_ctrl),
        .result   (result),
        .zero     (zero),
        .overflow (overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (op=%0d funct=%0d a=%0d b=%0d)",
                     tag, act, exp, alu_op, funct, opa, opb);
        end
    endtask

    function automatic int exp_code(input int op, input int f);
        if (op == 0) return 6;
        if (op == 1) return 14;
        if (op == 3) return 4;
        case (f % 16)
            0:  return 6;
            2:  return 14;
            4:  return 0;
            5:  return 1;
            6:  return 2;
            7:  return 3;
            10: return 15;
            default: return 4;
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v >= HALF) ? v - SPAN : v;
    endfunction

    function automatic int exp_res(input int code, input int a, input int b);
        case (code)
            0:  return a & b;
            1:  return a | b;
            2:  return a ^ b;
            3:  return (~(a | b)) & (SPAN - 1);
            6:  return (a + b) % SPAN;
            14: return (a - b + SPAN) % SPAN;
            15: return (sx(a) < sx(b)) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ovf(input int code, input int a, input int b);
        int s;
        if (code == 6)       s = sx(a) + sx(b);
        else if (code == 14) s = sx(a) - sx(b);
        else return 0;
        return (s < -HALF || s >= HALF) ? 1 : 0;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0, 1, 2, 3: return "R4";
            6, 14:      return "R5";
            15:         return "R6";
            default:    return "R9";
        endcase
    endfunction

    task automatic apply(input int op, input int f, input int a, input int b);
        @(posedge clk);
        #1;
        alu_op = op[1:0];
        funct  = f[5:0];
        opa    = a[W-1:0];
        opb    = b[W-1:0];
        @(negedge clk);
    endtask

    task automatic check_outputs(input int code, input int a, input int b);
        int er;
        int eo;
        er = exp_res(code, a, b);
        eo = exp_ovf(code, a, b);
        check(int'(result) == er, tag_of(code), int'(result), er);
        check(zero == (er == 0), "R7", int'(zero), int'(er == 0));
        check(overflow == eo[0], "R8", int'(overflow), eo);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WDOG_LIMIT, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ops[7][2];
        ops = '{'{0, 0}, '{1, 0}, '{2, 36}, '{2, 21}, '{2, 38}, '{2, 55}, '{2, 42}};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give an add of zeros.
        @(negedge clk);
        check(alu_ctrl == 4'b0110, "R1", int'(alu_ctrl), 6);
        check(result == '0 && zero && !overflow, "R7", int'(result), 0);

        // Decode sweep over every class and function field value.
        for (int op = 0; op < 4; op++) begin
            for (int f = 0; f < 64; f++) begin
                int ec;
                string t;
                ec = exp_code(op, f);
                t = (op == 0) ? "R1" : (op == 1) ? "R2" : (op == 3 || ec == 4) ? "R9" : "R3";
                apply(op, f, 13, 6);
                check(int'(alu_ctrl) == ec, t, int'(alu_ctrl), ec);
                check_outputs(ec, 13, 6);
            end
        end

        // Exhaustive operand sweep per operation, rotating don't-care funct bits.
        for (int k = 0; k < 7; k++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    int f;
                    int ec;
                    f  = ops[k][1] ^ (((a + b) % 4) << 4);
                    ec = exp_code(ops[k][0], f);
                    apply(ops[k][0], f, a, b);
                    check_outputs(ec, a, b);
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule